// File: doc/BRIEF.md
# Latched Address Decoder with Output Enables

This block turns a small binary select code into a one-of-N pattern of active-low lines, with a register in front of the decode that can freeze the code. While the hold input is low the register follows the select bus on every clock edge. On the first edge at which hold is seen high after being low, the register takes the select value of that edge and keeps it. Later select changes are ignored until hold drops again. The held code can drive a chip-select or strobe fan-out that must not glitch while the upstream bus changes.

Two output enables of opposite polarity gate all lines together. The lines are active only when the high-true enable is 1 and the low-true enable is 0. The gating works after the register, so the held code can be blanked and shown again without being lost. Because the hold input is sampled on the system clock, the whole block is built from flip-flops, with no level-sensitive latch. The default width is a 3-bit code and 8 outputs.

Top module: `addr_latch_decoder`

## Requirements
- R1: When the outputs are enabled, exactly one bit of `dec_n_o` is 0 and all other bits are 1.
- R2: The code is binary with `sel_i[SEL_W-1]` as the most significant bit. A stored code of value n drives `dec_n_o[n]` low, so 3'b000 selects bit 0 and 3'b111 selects bit 7.
- R3: At a clock edge where `hold_i` is 0, the stored code takes the value of `sel_i`. The outputs show it from that edge until the next one.
- R4: At the first clock edge where `hold_i` is 1 after an edge where it was 0, the stored code takes the value of `sel_i` at that edge.
- R5: At a clock edge where `hold_i` is 1 and was also 1 at the previous edge, `sel_i` has no effect: the outputs keep the previous selection.
- R6: All bits of `dec_n_o` are 1 unless `en_hi_i` is 1 and `en_lo_n_i` is 0. This holds for any hold state and select value, and takes effect without waiting for a clock edge.
- R7: The enables never change the stored code. After the outputs have been blanked for any number of cycles with `hold_i` high, enabling them again shows the same selection as before.
- R8: Driving `rst_n` low clears the stored code to 0 at once, without a clock. Release is resynchronised over two clock edges, and the first update can happen on the third edge after release. After reset the hold state counts as held, so a high `hold_i` captures nothing until it has been seen low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | SEL_W | Binary select code |
| hold_i | input | 1 | 0: register follows `sel_i`; 1: code captured on first high edge, then frozen |
| en_hi_i | input | 1 | Output enable, active high |
| en_lo_n_i | input | 1 | Output enable, active low |
| dec_n_o | output | 2**SEL_W | Active-low one-of-N decode outputs |

## Verification
The capture edge and a change of select value can fall in the same cycle. The bench raises `hold_i` together with a new select value, so the frozen code must be the new value and not the one from the last open edge. Enable gating and a held-address update can also coincide. The bench toggles the enables on the capture edge and while changing `sel_i` under hold, and then compares every cycle against a behavioural model that stores the code independently of the outputs. An asynchronous reset asserted mid-cycle is judged within the same clock period.

// File: rtl/ald_pkg.sv
package ald_pkg;
  // Whether the previous clock edge saw the hold input high.
  typedef enum logic {
    HOLD_OPEN = 1'b0,
    HOLD_SEEN = 1'b1
  } hold_state_e;
endpackage

// File: rtl/ald_rst_sync.sv
module ald_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/ald_addr_store.sv
module ald_addr_store
  import ald_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             hold_i,
  output logic [SEL_W-1:0] addr_o
);
  logic [SEL_W-1:0] addr_q;
  logic [SEL_W-1:0] addr_d;
  hold_state_e      st_q;
  hold_state_e      st_d;
  logic             load_en;

  // Load on open edges and on the first held edge; freeze afterwards.
  always_comb begin
    load_en = !(hold_i && (st_q == HOLD_SEEN));
    addr_d  = addr_q;
    if (load_en) begin
      addr_d = sel_i;
    end
    st_d = hold_i ? HOLD_SEEN : HOLD_OPEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      st_q   <= HOLD_SEEN;
    end else begin
      addr_q <= addr_d;
      st_q   <= st_d;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/ald_decode.sv
module ald_decode #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned N_OUT = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] addr_i,
  input  logic             en_hi_i,
  input  logic             en_lo_n_i,
  output logic [N_OUT-1:0] dec_n_o
);
  logic gate_on;

  assign gate_on = en_hi_i & ~en_lo_n_i;

  for (genvar gi = 0; gi < N_OUT; gi++) begin : g_line
    assign dec_n_o[gi] = ~(gate_on && (addr_i == SEL_W'(gi)));
  end
endmodule

// File: rtl/addr_latch_decoder.sv
module addr_latch_decoder #(
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic                    hold_i,
  input  logic                    en_hi_i,
  input  logic                    en_lo_n_i,
  output logic [(1<<SEL_W)-1:0]   dec_n_o
);
  localparam int unsigned N_OUT = 1 << SEL_W;

  logic             rst_int_n;
  logic [SEL_W-1:0] addr_w;
  logic [N_OUT-1:0] dec_w;

  ald_rst_sync #(
    .STAGES(RST_STAGE)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  ald_addr_store #(
    .SEL_W(SEL_W)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sel_i  (sel_i),
    .hold_i (hold_i),
    .addr_o (addr_w)
  );

  ald_decode #(
    .SEL_W(SEL_W)
  ) u_decode (
    .addr_i    (addr_w),
    .en_hi_i   (en_hi_i),
    .en_lo_n_i (en_lo_n_i),
    .dec_n_o   (dec_w)
  );

  assign dec_n_o = dec_w;
endmodule

// File: rtl/addr_latch_decoder_chk.sv
module addr_latch_decoder_chk #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned N_OUT = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] sel_i,
  input logic             hold_i,
  input logic             en_hi_i,
  input logic             en_lo_n_i,
  input logic [N_OUT-1:0] dec_n_o
);
  logic [1:0] run_cnt;
  logic       en_ok;

  assign en_ok = en_hi_i & ~en_lo_n_i;

  // Edges since reset release; saturates once the store is live.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (run_cnt != 2'd3) begin
      run_cnt <= run_cnt + 2'd1;
    end
  end

  p_single_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en_ok |-> ($countones(~dec_n_o) == 1));

  // Also covers the code-to-line mapping of R2.
  p_follow_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt == 2'd3 && en_ok && !$past(hold_i))
      |-> (dec_n_o == ~(N_OUT'(1) << $past(sel_i))));

  p_capture_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt == 2'd3 && en_ok && $past(hold_i) && !$past(hold_i, 2))
      |-> (dec_n_o == ~(N_OUT'(1) << $past(sel_i))));

  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt == 2'd3 && en_ok && $past(en_ok) && $past(hold_i) && $past(hold_i, 2))
      |-> $stable(dec_n_o));

  p_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_ok |-> (dec_n_o == {N_OUT{1'b1}}));

  always @(negedge clk) begin
    if (!rst_n && en_ok) begin
      p_reset_zero_r8: assert (dec_n_o == ~N_OUT'(1));
    end
  end
endmodule

bind addr_latch_decoder addr_latch_decoder_chk #(
  .SEL_W(SEL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_i     (sel_i),
  .hold_i    (hold_i),
  .en_hi_i   (en_hi_i),
  .en_lo_n_i (en_lo_n_i),
  .dec_n_o   (dec_n_o)
);

// File: tb/addr_latch_decoder_tb_top.sv
module addr_latch_decoder_tb_top;
  localparam int SEL_W = 3;
  localparam int N_OUT = 8;

  logic             clk;
  logic             rst_n;
  logic [SEL_W-1:0] sel;
  logic             hold;
  logic             en_hi;
  logic             en_lo_n;
  logic [N_OUT-1:0] dec_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Behavioural reference state
  int m_code;
  bit m_held;
  int m_rel;

  addr_latch_decoder #(.SEL_W(SEL_W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (sel),
    .hold_i    (hold),
    .en_hi_i   (en_hi),
    .en_lo_n_i (en_lo_n),
    .dec_n_o   (dec_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code <= 0;
      m_held <= 1'b1;
      m_rel  <= 0;
    end else if (m_rel < 2) begin
      m_rel <= m_rel + 1;
    end else begin
      if (!(hold && m_held)) m_code <= int'(sel);
      m_held <= hold;
    end
  end

  task automatic check(input string tag);
    logic [N_OUT-1:0] exp;
    bit on;
    on = en_hi && !en_lo_n;
    exp = '1;
    if (on) exp[m_code] = 1'b0;
    total++;
    if (dec_n !== exp) begin
      bad++;
      $display("FAIL %s: dec_n=%b expected=%b", on ? tag : "R6", dec_n, exp);
    end
    if (on) begin
      total++;
      if ($countones(~dec_n) != 1) begin
        bad++;
        $display("FAIL R1: low count=%0d expected=1", $countones(~dec_n));
      end
    end
  endtask

  // Drive at a falling edge, then compare at the next falling edge.
  task automatic step(input int s, input bit h, input bit eh, input bit el, input string tag);
    sel = SEL_W'(s); hold = h; en_hi = eh; en_lo_n = el;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: finished=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sel = 3'd5; hold = 1'b1; en_hi = 1'b1; en_lo_n = 1'b0;
    @(negedge clk);
    check("R8");
    @(negedge clk);
    rst_n = 1'b1;
    // R8: held after reset, code stays 0 although sel=5
    for (int i = 0; i < 4; i++) step(5, 1, 1, 0, "R8");

    // R6 / R2: every enable pair against every code, register open
    for (int e = 0; e < 4; e++)
      for (int c = 0; c < N_OUT; c++)
        step(c, 0, e[1], e[0], "R2");

    // R3: open register tracks a walking pattern
    for (int c = N_OUT - 1; c >= 0; c--) step(c ^ 3, 0, 1, 0, "R3");

    // R4: capture edge coincides with a new select value
    step(3, 0, 1, 0, "R3");
    step(6, 1, 1, 0, "R4");
    // R5: select changes while held are ignored
    for (int c = 0; c < N_OUT; c++) step(c, 1, 1, 0, "R5");

    // R7: blank with either enable, change sel, then re-enable
    for (int c = 0; c < 4; c++) step(c, 1, 0, 0, "R6");
    for (int c = 4; c < 8; c++) step(c, 1, 1, 1, "R6");
    step(1, 1, 1, 0, "R7");
    step(2, 1, 1, 0, "R7");
    // R4: capture edge while blanked, shown after re-enable
    step(4, 0, 1, 0, "R3");
    step(7, 1, 0, 1, "R6");
    step(0, 1, 1, 0, "R7");

    // R8: asynchronous clear mid-cycle
    @(posedge clk);
    #3 rst_n = 1'b0;
    #1 check("R8");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(5, 0, 1, 0, "R8");
    step(5, 0, 1, 0, "R3");
    step(2, 1, 1, 0, "R4");
    step(7, 1, 1, 0, "R5");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule